// File: doc/BRIEF.md
# Selector Pointer Validation Unit

This unit carries out the five selector-checking operations of a segmented protected-mode processor. The operations are the privilege adjustment of a selector, the read and write verification of a segment, and two loads: one for a segment's limit and one for its access-rights byte. It never faults. Every outcome is reported through a zero flag and, where the operation produces a value, a result word with a one-cycle write enable. The surrounding pipeline has already fetched the descriptor named by the selector. It presents that descriptor together with the operation code, the current privilege level and, for the adjust operation, a second register operand.

A one-cycle `start` pulse launches an operation. In the following cycle `done` is high, and the result word, its write enable and the zero flag are valid. The result word and the zero flag then hold their values until the next operation. The unit accepts a new operation in every cycle, so back-to-back starts are allowed.

Top module: `selchk_unit`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle with `start` high, and low in every other cycle, including the first cycle after reset.
- R2: Adjust (opcode 0) writes the selector with its low two bits (the RPL) replaced by the larger of that RPL and bits 1:0 of `srcOperand`, zero-extended to 32 bits. `resultWe` pulses whether or not `descValid` is high.
- R3: Adjust sets the zero flag only when the RPL field changed; otherwise it clears the flag.
- R4: Access byte layout: bit 6:5 DPL, bit 4 set for code/data segments, bit 3 code, bit 2 conforming (code only), bit 1 readable for code or writable for data. Bit 7 is not examined. The privilege test passes when max(`cpl`, selector bits 1:0) is numerically less than or equal to the DPL.
- R5: Verify-read (opcode 1) sets the zero flag for a code/data segment that is either data or readable code, and that passes the privilege test. It never writes a result.
- R6: Verify-write (opcode 2) sets the zero flag only for a writable data segment that passes the privilege test. Code segments always fail. It never writes a result.
- R7: Load-limit (opcode 3) succeeds for any code/data segment passing the privilege test. On success it writes the limit and sets the zero flag. The limit is zero-extended, or, with `descGran` set, shifted left by 12 with the low 12 bits set to one.
- R8: Load-rights (opcode 4) succeeds under the same conditions as load-limit. On success it writes the access byte in result bits 15:8, with all other bits zero, and sets the zero flag.
- R9: A readable conforming code segment passes the privilege test at any privilege level, for every operation that applies the test.
- R10: A system descriptor (bit 4 clear) makes every operation except adjust clear the zero flag and write nothing.
- R11: With `descValid` low, every operation except adjust clears the zero flag, writes nothing and leaves `resultData` unchanged.
- R12: Opcodes 5 to 7 clear the zero flag, write nothing and leave `resultData` unchanged.
- R13: Reset clears all outputs. When a check fails, `resultData` keeps its previous value. Between operations `resultWe` is low and `resultData` and `zeroFlag` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one operation this cycle |
| opcode | input | 3 | Operation select (0 to 4, others unused) |
| cpl | input | 2 | Current privilege level |
| selector | input | 16 | Selector under test |
| srcOperand | input | 16 | Second register operand for adjust |
| descAccess | input | 8 | Access byte of the fetched descriptor |
| descLimit | input | 20 | Raw segment limit |
| descGran | input | 1 | Page granularity of the limit |
| descValid | input | 1 | Descriptor fetch succeeded |
| done | output | 1 | Outputs valid for the last accepted operation |
| resultData | output | 32 | Result word |
| resultWe | output | 1 | Write enable for the result word |
| zeroFlag | output | 1 | Success flag |

## Verification
All state in this unit lives in the output registers and the `done` flag. A wrong internal decision therefore shows at the ports one cycle after the `start` that caused it, as a wrong zero flag, a spurious or missing write pulse, or a changed held result. A stale or corrupted hold value shows in the idle cycle that follows each operation. The vectors pair each privilege-rule path with an operation that depends on it. Failed operations are placed directly after successful ones, so that a flag or result that should have been cleared or kept becomes visible.

// File: rtl/selchk_pkg.sv
package selchk_pkg;

  localparam int OP_W  = 3;
  localparam int RPL_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADJUST      = 3'd0,
    OP_VERIFY_RD   = 3'd1,
    OP_VERIFY_WR   = 3'd2,
    OP_LOAD_LIMIT  = 3'd3,
    OP_LOAD_RIGHTS = 3'd4
  } selOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch a new outcome
    logic clearWe;   // drop the write pulse
  } ctrlStrobe_t;

  // descriptor access byte as seen by the rules
  typedef struct packed {
    logic             present;
    logic [RPL_W-1:0] dpl;
    logic             isSegment;
    logic             isCode;
    logic             conforming;
    logic             rdWr;
    logic             accessed;
  } accessByte_t;

endpackage

// File: rtl/selchk_rules.sv
module selchk_rules
  import selchk_pkg::*;
#(
  parameter int PL_W = RPL_W
) (
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] selRpl,
  input  logic [PL_W-1:0] dpl,
  input  logic            isSegment,
  input  logic            isCode,
  input  logic            conforming,
  input  logic            rdWr,
  input  logic            descValid,
  output logic            readOk,
  output logic            writeOk,
  output logic            loadOk
);

  logic [PL_W-1:0] effLevel;
  logic            levelOk;
  logic            confReadable;
  logic            privPass;
  logic            segUsable;

  always_comb begin
    effLevel     = (cpl > selRpl) ? cpl : selRpl;
    levelOk      = (effLevel <= dpl);
    confReadable = isCode & conforming & rdWr;
    privPass     = levelOk | confReadable;
    segUsable    = descValid & isSegment;
    readOk       = segUsable & (~isCode | rdWr) & privPass;
    writeOk      = segUsable & ~isCode & rdWr & levelOk;
    loadOk       = segUsable & privPass;
  end

  always_comb begin
    if (writeOk) begin
      assert_write_implies_read_R6 : assert (readOk);
    end
    if (!descValid) begin
      assert_invalid_blocks_all_R11 : assert (!readOk && !writeOk && !loadOk);
    end
  end

endmodule

// File: rtl/selchk_datapath.sv
module selchk_datapath
  import selchk_pkg::*;
#(
  parameter int SEL_W      = 16,
  parameter int RES_W      = 32,
  parameter int LIMIT_W    = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int ACC_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [OP_W-1:0]   opcode,
  input  logic [RPL_W-1:0]  cpl,
  input  logic [SEL_W-1:0]  selector,
  input  logic [SEL_W-1:0]  srcOperand,
  input  logic [ACC_W-1:0]  descAccess,
  input  logic [LIMIT_W-1:0] descLimit,
  input  logic              descGran,
  input  logic              descValid,
  output logic [RES_W-1:0]  resultQ,
  output logic              resultWeQ,
  output logic              zeroQ
);

  localparam int BYTE_PAD   = RES_W - ACC_W - 8;
  localparam int SEL_PAD    = RES_W - SEL_W;
  localparam int BYTE_PAD_W = RES_W - LIMIT_W;
  localparam int PAGED_PAD  = RES_W - LIMIT_W - PAGE_SHIFT;

  accessByte_t        acc;
  logic [RPL_W-1:0]   selRpl;
  logic [RPL_W-1:0]   srcRpl;
  logic [RPL_W-1:0]   newRpl;
  logic               readOk, writeOk, loadOk;
  logic [RES_W-1:0]   adjustWord, rightsWord, limitWord, byteLimit, pagedLimit;
  logic [RES_W-1:0]   nextRes;
  logic               nextWe, nextZf;
  logic               unusedSrcHigh;

  assign acc           = accessByte_t'(descAccess);
  assign selRpl        = selector[RPL_W-1:0];
  assign srcRpl        = srcOperand[RPL_W-1:0];
  assign unusedSrcHigh = ^srcOperand[SEL_W-1:RPL_W] ^ acc.present;

  selchk_rules #(.PL_W(RPL_W)) u_rules (
    .cpl        (cpl),
    .selRpl     (selRpl),
    .dpl        (acc.dpl),
    .isSegment  (acc.isSegment),
    .isCode     (acc.isCode),
    .conforming (acc.conforming),
    .rdWr       (acc.rdWr),
    .descValid  (descValid),
    .readOk     (readOk),
    .writeOk    (writeOk),
    .loadOk     (loadOk)
  );

  // limit expansion: the padding width depends on the parameters
  assign byteLimit = {{BYTE_PAD_W{1'b0}}, descLimit};
  generate
    if (PAGED_PAD > 0) begin : g_pagedPad
      assign pagedLimit = {{PAGED_PAD{1'b0}}, descLimit, {PAGE_SHIFT{1'b1}}};
    end else begin : g_pagedFull
      logic [LIMIT_W+PAGE_SHIFT-1:0] wideLimit;
      assign wideLimit  = {descLimit, {PAGE_SHIFT{1'b1}}};
      assign pagedLimit = wideLimit[RES_W-1:0];
    end
  endgenerate

  always_comb begin
    newRpl     = (srcRpl > selRpl) ? srcRpl : selRpl;
    adjustWord = {{SEL_PAD{1'b0}}, selector[SEL_W-1:RPL_W], newRpl};
    rightsWord = {{BYTE_PAD{1'b0}}, descAccess, 8'h00};
    limitWord  = descGran ? pagedLimit : byteLimit;
  end

  always_comb begin
    nextRes = resultQ;
    nextWe  = 1'b0;
    nextZf  = 1'b0;
    case (opcode)
      OP_ADJUST: begin
        nextRes = adjustWord;
        nextWe  = 1'b1;
        nextZf  = (newRpl != selRpl);
      end
      OP_VERIFY_RD: nextZf = readOk;
      OP_VERIFY_WR: nextZf = writeOk;
      OP_LOAD_LIMIT: begin
        nextRes = loadOk ? limitWord : resultQ;
        nextWe  = loadOk;
        nextZf  = loadOk;
      end
      OP_LOAD_RIGHTS: begin
        nextRes = loadOk ? rightsWord : resultQ;
        nextWe  = loadOk;
        nextZf  = loadOk;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ   <= '0;
      resultWeQ <= 1'b0;
      zeroQ     <= 1'b0;
    end else if (strobe.capture) begin
      resultQ   <= nextRes;
      resultWeQ <= nextWe;
      zeroQ     <= nextZf;
    end else if (strobe.clearWe) begin
      resultWeQ <= 1'b0;
    end
  end

  assert_adjust_writes_R2 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && opcode == OP_ADJUST |=>
      resultWeQ && resultQ[SEL_W-1:RPL_W] == $past(selector[SEL_W-1:RPL_W])
      && resultQ[RPL_W-1:0] >= $past(selector[RPL_W-1:0]));

  assert_adjust_flag_R3 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && opcode == OP_ADJUST |=>
      zeroQ == (resultQ[RPL_W-1:0] != $past(selector[RPL_W-1:0])));

  assert_verify_no_write_R5 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && (opcode == OP_VERIFY_RD || opcode == OP_VERIFY_WR) |=>
      !resultWeQ && $stable(resultQ));

  assert_invalid_desc_R11 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && !descValid && opcode != OP_ADJUST |=>
      !resultWeQ && !zeroQ && $stable(resultQ));

  assert_unused_op_R12 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && opcode > OP_LOAD_RIGHTS |=>
      !resultWeQ && !zeroQ && $stable(resultQ));

  assert_idle_hold_R13 : assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !resultWeQ && $stable(zeroQ) && $stable(resultQ));

  assert_write_flags_R7 : assert property (@(posedge clk) disable iff (!rstN)
    resultWeQ && $past(opcode) != OP_ADJUST |-> zeroQ);

endmodule

// File: rtl/selchk_ctrl.sv
module selchk_ctrl
  import selchk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t strobe,
  output logic        doneQ
);

  always_comb begin
    strobe.capture = start;
    strobe.clearWe = ~start;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= start;
  end

  assert_done_after_start_R1 : assert property (@(posedge clk) disable iff (!rstN)
    start |=> doneQ);

  assert_no_spurious_done_R1 : assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !doneQ);

endmodule

// File: rtl/selchk_unit.sv
module selchk_unit
  import selchk_pkg::*;
#(
  parameter int SEL_W      = 16,
  parameter int RES_W      = 32,
  parameter int LIMIT_W    = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int ACC_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [OP_W-1:0]    opcode,
  input  logic [RPL_W-1:0]   cpl,
  input  logic [SEL_W-1:0]   selector,
  input  logic [SEL_W-1:0]   srcOperand,
  input  logic [ACC_W-1:0]   descAccess,
  input  logic [LIMIT_W-1:0] descLimit,
  input  logic               descGran,
  input  logic               descValid,
  output logic               done,
  output logic [RES_W-1:0]   resultData,
  output logic               resultWe,
  output logic               zeroFlag
);

  ctrlStrobe_t strobe;

  selchk_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .doneQ  (done)
  );

  selchk_datapath #(
    .SEL_W      (SEL_W),
    .RES_W      (RES_W),
    .LIMIT_W    (LIMIT_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ACC_W      (ACC_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opcode     (opcode),
    .cpl        (cpl),
    .selector   (selector),
    .srcOperand (srcOperand),
    .descAccess (descAccess),
    .descLimit  (descLimit),
    .descGran   (descGran),
    .descValid  (descValid),
    .resultQ    (resultData),
    .resultWeQ  (resultWe),
    .zeroQ      (zeroFlag)
  );

  assert_write_only_with_done_R13 : assert property (@(posedge clk) disable iff (!rstN)
    resultWe |-> done);

endmodule

// File: tb/selchk_unit_tb.sv
`timescale 1ns/1ps
module selchk_unit_tb;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [1:0]  cpl;
    logic [15:0] sel;
    logic [15:0] src;
    logic [7:0]  acc;
    logic [19:0] lim;
    logic        gran;
    logic        valid;
    logic        expWe;
    logic        expZf;
    logic [31:0] expRes;
  } vec_t;

  localparam int NUM_VECS = 24;
  // access bytes: F2 data rw dpl3, 90 data ro dpl0, 9A code rd dpl0,
  // 9E conforming code rd dpl0, F8 exec-only dpl3, E2 system dpl3, B2 data rw dpl1
  localparam vec_t VECS [NUM_VECS] = '{
    '{4'd2,  3'd0, 2'd0, 16'h0010, 16'h0003, 8'hF2, 20'h0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0013}, // R2 R3 raise
    '{4'd3,  3'd0, 2'd0, 16'h002B, 16'h0001, 8'hF2, 20'h0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_002B}, // R3 no change
    '{4'd2,  3'd0, 2'd0, 16'h0029, 16'hFFFE, 8'hF2, 20'h0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_002A}, // R2 high src bits ignored
    '{4'd5,  3'd1, 2'd3, 16'h0003, 16'h0000, 8'hF2, 20'h0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0},          // R5 data readable
    '{4'd4,  3'd1, 2'd3, 16'h0000, 16'h0000, 8'h90, 20'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},          // R4 cpl too weak
    '{4'd4,  3'd1, 2'd0, 16'h0003, 16'h0000, 8'h90, 20'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},          // R4 rpl too weak
    '{4'd5,  3'd1, 2'd0, 16'h0000, 16'h0000, 8'hF8, 20'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},          // R5 exec-only
    '{4'd9,  3'd1, 2'd3, 16'h0003, 16'h0000, 8'h9E, 20'h0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0},          // R9 conforming read
    '{4'd6,  3'd2, 2'd1, 16'h0001, 16'h0000, 8'hB2, 20'h0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0},          // R6 equal level
    '{4'd6,  3'd2, 2'd0, 16'h0000, 16'h0000, 8'h9A, 20'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},          // R6 code never writable
    '{4'd6,  3'd2, 2'd0, 16'h0000, 16'h0000, 8'h90, 20'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},          // R6 read-only data
    '{4'd7,  3'd3, 2'd0, 16'h0000, 16'h0000, 8'h9A, 20'h12345, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0001_2345}, // R7 byte limit
    '{4'd7,  3'd3, 2'd2, 16'h0002, 16'h0000, 8'hF2, 20'h00ABC, 1'b1, 1'b1, 1'b1, 1'b1, 32'h00AB_CFFF}, // R7 page limit
    '{4'd7,  3'd3, 2'd3, 16'h0000, 16'h0000, 8'h9A, 20'h00001, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},        // R7 fail holds
    '{4'd8,  3'd4, 2'd0, 16'h0000, 16'h0000, 8'h9A, 20'h0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_9A00},   // R8 rights
    '{4'd9,  3'd4, 2'd3, 16'h0003, 16'h0000, 8'h9E, 20'h0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_9E00},   // R9 conforming rights
    '{4'd10, 3'd4, 2'd3, 16'h0003, 16'h0000, 8'hE2, 20'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},          // R10 system rights
    '{4'd10, 3'd3, 2'd0, 16'h0000, 16'h0000, 8'hE2, 20'h5, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},          // R10 system limit
    '{4'd11, 3'd0, 2'd0, 16'h0000, 16'h0002, 8'hF2, 20'h0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0002},   // R11 adjust ignores valid
    '{4'd11, 3'd1, 2'd0, 16'h0000, 16'h0000, 8'hF2, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},          // R11 read blocked
    '{4'd9,  3'd3, 2'd3, 16'h0003, 16'h0000, 8'h9E, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF}, // R9 conforming limit
    '{4'd11, 3'd4, 2'd0, 16'h0000, 16'h0000, 8'hF2, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0},          // R11 rights blocked
    '{4'd12, 3'd5, 2'd0, 16'h0000, 16'h0003, 8'hF2, 20'h1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0},          // R12 op 5
    '{4'd12, 3'd7, 2'd0, 16'h0000, 16'h0000, 8'hF2, 20'h1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0}           // R12 op 7
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [2:0]  opcode;
  logic [1:0]  cpl;
  logic [15:0] selector, srcOperand;
  logic [7:0]  descAccess;
  logic [19:0] descLimit;
  logic        descGran, descValid;
  logic        done, resultWe, zeroFlag;
  logic [31:0] resultData;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] heldRes;
  logic        heldZf;

  always #4 clk = ~clk;

  selchk_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .cpl(cpl),
    .selector(selector), .srcOperand(srcOperand), .descAccess(descAccess),
    .descLimit(descLimit), .descGran(descGran), .descValid(descValid),
    .done(done), .resultData(resultData), .resultWe(resultWe), .zeroFlag(zeroFlag)
  );

  task automatic compare(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opcode = v.op; cpl = v.cpl; selector = v.sel; srcOperand = v.src;
    descAccess = v.acc; descLimit = v.lim; descGran = v.gran; descValid = v.valid;
    start = 1'b1;
  endtask

  // checks one finished operation; sample after the capturing edge
  task automatic checkDone(input vec_t v);
    compare(1, "done", {31'b0, done}, 32'd1);                       // R1
    compare(v.req, "resultWe", {31'b0, resultWe}, {31'b0, v.expWe});
    compare(v.req, "zeroFlag", {31'b0, zeroFlag}, {31'b0, v.expZf});
    if (v.expWe) heldRes = v.expRes;
    compare(v.req, "resultData", resultData, heldRes);              // R13 hold on failure
    heldZf = v.expZf;
  endtask

  task automatic checkIdle();
    compare(1, "done idle", {31'b0, done}, 32'd0);                  // R1
    compare(13, "resultWe idle", {31'b0, resultWe}, 32'd0);         // R13
    compare(13, "zeroFlag hold", {31'b0, zeroFlag}, {31'b0, heldZf});
    compare(13, "resultData hold", resultData, heldRes);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; opcode = '0; cpl = '0; selector = '0;
    srcOperand = '0; descAccess = '0; descLimit = '0; descGran = 1'b0; descValid = 1'b0;
    heldRes = '0; heldZf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R13 reset state
    compare(13, "reset done", {31'b0, done}, 32'd0);
    compare(13, "reset resultWe", {31'b0, resultWe}, 32'd0);
    compare(13, "reset zeroFlag", {31'b0, zeroFlag}, 32'd0);
    compare(13, "reset resultData", resultData, 32'd0);

    for (int i = 0; i < NUM_VECS; i++) begin
      @(negedge clk) drive(VECS[i]);
      @(negedge clk) begin
        start = 1'b0;
        checkDone(VECS[i]);
      end
      @(negedge clk) checkIdle();
    end

    // R1 back-to-back: adjust then rights, one start per cycle
    @(negedge clk) drive(VECS[0]);
    @(negedge clk) begin
      checkDone(VECS[0]);
      drive(VECS[14]);
    end
    @(negedge clk) begin
      start = 1'b0;
      checkDone(VECS[14]);
    end
    @(negedge clk) checkIdle();

    // R11 with invalid descriptor after a success: result must stay 0x9A00
    @(negedge clk) drive(VECS[21]);
    @(negedge clk) begin
      start = 1'b0;
      checkDone(VECS[21]);
    end

    // R13 reset mid-stream clears everything
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) begin
      rstN = 1'b1;
      compare(13, "rereset resultData", resultData, 32'd0);
      compare(13, "rereset zeroFlag", {31'b0, zeroFlag}, 32'd0);
      compare(1, "rereset done", {31'b0, done}, 32'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule